// File: doc/BRIEF.md
# Two-Port Link Slot Arbiter with Split Command Credits

This block decides, slot by slot, which end of a point-to-point link may transmit. One end is the privileged module side and the other is the adapter side. The module side wins any slot in which it has an eligible request. A response is always eligible. A command is eligible when the sender still holds a credit for the matching class of buffer at its peer. Any slot the module side does not take goes to the adapter side, subject to the same credit rule. If the adapter side has nothing eligible, nobody transmits.

Each side's view of its peer's free buffers is kept in two saturating counters. One pool is for read and modify commands and the other is for write commands. A granted command takes one credit from the right pool on the grant edge. The receiving side returns credits one at a time with buffer-freed strobes, and it can zero both pools with a clear strobe. A granted modify command locks out modify commands from the other side. The lock holder's next granted write releases it.

Top module: `link_slot_arbiter`

## Requirements
- R1: While reset is low at a clock edge, both grants, all four credit counts and both lock outputs are 0 after that edge.
- R2: A module-side request whose kind is a response (4 read data, 5 error data, 6 error) is granted in the next slot, whatever the credit counts are.
- R3: A command request is eligible only if its matching credit count is nonzero. Read (1) and modify (3) use the read/modify pool. Write (2) uses the write pool. A credit returned on the same edge does not count.
- R4: At most one grant is high per slot. When the module side is eligible, the adapter side is not granted.
- R5: When the module side is not eligible, an eligible adapter request is granted. With no eligible adapter request, neither grant is high.
- R6: Kinds 0 and 7 are illegal and are never granted. A side with its request low is never granted.
- R7: A granted command decrements the sender's matching pool by one on the grant edge. A granted response changes no count.
- R8: A buffer-freed strobe adds one to its pool. The count saturates at 7. An increment and a decrement on the same edge leave the count unchanged.
- R9: A clear strobe from a receiver sets both pools held for it to 0 on that edge, overriding any increment or decrement.
- R10: A granted modify sets the lock and records its side (lock_by_adp = 1 for the adapter). While locked, a modify from the other side is not eligible, but its reads and writes are. A granted write from the lock owner releases the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_req | input | 1 | Module side wants the next slot |
| mod_kind | input | 3 | Module side transmission kind code |
| adp_req | input | 1 | Adapter side wants the next slot |
| adp_kind | input | 3 | Adapter side transmission kind code |
| adp_free_rm | input | 1 | Adapter freed a read/modify buffer (credits module side) |
| adp_free_wr | input | 1 | Adapter freed a write buffer (credits module side) |
| adp_credit_clr | input | 1 | Adapter zeroes both module-side pools |
| mod_free_rm | input | 1 | Module freed a read/modify buffer (credits adapter side) |
| mod_free_wr | input | 1 | Module freed a write buffer (credits adapter side) |
| mod_credit_clr | input | 1 | Module zeroes both adapter-side pools |
| mod_grant | output | 1 | Module side owns this slot |
| adp_grant | output | 1 | Adapter side owns this slot |
| mod_cred_rm | output | 3 | Module side's read/modify credits for the adapter |
| mod_cred_wr | output | 3 | Module side's write credits for the adapter |
| adp_cred_rm | output | 3 | Adapter side's read/modify credits for the module |
| adp_cred_wr | output | 3 | Adapter side's write credits for the module |
| lock_held | output | 1 | An interlocked sequence is open |
| lock_by_adp | output | 1 | The lock belongs to the adapter side |

## Verification
On a single edge, one pool can see both a grant that consumes a credit and a buffer-freed strobe that returns one. The bench provokes this in two ways. First, it returns a write credit to an empty pool while the module requests a write: the request must lose, because a credit arriving on the same edge does not count. Then, on the next slot, it returns another credit while the write is granted: the count must stay at one. The bench also lets the lock-releasing write coincide with this return, and the lock must drop in that same slot.

// File: rtl/link_arb_pkg.sv
// Package: kind codes and classification helpers shared by the link arbiter.
// Assumes the kind field is the 3-bit class portion of the transmission type.
package link_arb_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_ILL_LO  = 3'd0,
        K_READ    = 3'd1,
        K_WRITE   = 3'd2,
        K_MODIFY  = 3'd3,
        K_RDATA   = 3'd4,
        K_ERRDATA = 3'd5,
        K_ERR     = 3'd6,
        K_ILL_HI  = 3'd7
    } link_kind_e;

    // Responses travel without any credit.
    function automatic logic kind_is_resp(input logic [KIND_W-1:0] k);
        return (k == K_RDATA) || (k == K_ERRDATA) || (k == K_ERR);
    endfunction

    // Commands drawing on the read/modify buffer pool.
    function automatic logic kind_uses_rm(input logic [KIND_W-1:0] k);
        return (k == K_READ) || (k == K_MODIFY);
    endfunction

    // Commands drawing on the write buffer pool.
    function automatic logic kind_uses_wr(input logic [KIND_W-1:0] k);
        return (k == K_WRITE);
    endfunction

endpackage

// File: rtl/link_credit_ctr.sv
// Saturating credit counter for one buffer pool of one peer.
// Clear has priority. Otherwise the count adds one per return strobe, capped
// at the maximum, and subtracts one per consumed credit. The caller must
// never assert dec while the count is zero.
module link_credit_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Track the credit count with saturation and clear override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end else if (dec && !inc) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R7: a consumer is never granted against an empty pool
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));

    // R8: a full pool stays full under further returns
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == CNT_MAX && $past(inc) && !$past(dec) && !$past(clr) && $past(rst_n))
        |-> (cnt == CNT_MAX));

    // R9: clear always lands at zero
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (cnt == '0));

endmodule

// File: rtl/link_req_qual.sv
// Request qualifier for one side: decides whether this side's request may use
// the coming slot, given its peer credits and the interlock state.
// Assumes the kind code is stable for the slot being arbitrated.
module link_req_qual
    import link_arb_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              req,
    input  logic [KIND_W-1:0] kind,
    input  logic [CNT_W-1:0]  cred_rm,
    input  logic [CNT_W-1:0]  cred_wr,
    input  logic              lock_held,
    input  logic              lock_mine,
    output logic              elig,
    output logic              take_rm,
    output logic              take_wr,
    output logic              is_modify,
    output logic              is_write
);
    logic rm_ok;
    logic wr_ok;
    logic lock_ok;

    // Classify the request and check its credit and interlock conditions.
    always_comb begin
        is_modify = (kind == K_MODIFY);
        is_write  = (kind == K_WRITE);
        lock_ok   = !is_modify || !lock_held || lock_mine;
        rm_ok     = kind_uses_rm(kind) && (cred_rm != '0) && lock_ok;
        wr_ok     = kind_uses_wr(kind) && (cred_wr != '0);
        elig      = req && (kind_is_resp(kind) || rm_ok || wr_ok);
        take_rm   = req && rm_ok;
        take_wr   = req && wr_ok;
    end

endmodule

// File: rtl/link_slot_arbiter.sv
// Two-port link slot arbiter. Side 0 (module) has strict priority, and side 1
// (adapter) takes any slot side 0 leaves. Grants are registered: a request
// presented before edge k yields a grant that is visible after edge k. The
// credit pools and the interlock change on that same edge.
// Assumes each side holds its request until it sees the grant.
module link_slot_arbiter
    import link_arb_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_req,
    input  logic [KIND_W-1:0] mod_kind,
    input  logic              adp_req,
    input  logic [KIND_W-1:0] adp_kind,
    input  logic              adp_free_rm,
    input  logic              adp_free_wr,
    input  logic              adp_credit_clr,
    input  logic              mod_free_rm,
    input  logic              mod_free_wr,
    input  logic              mod_credit_clr,
    output logic              mod_grant,
    output logic              adp_grant,
    output logic [CNT_W-1:0]  mod_cred_rm,
    output logic [CNT_W-1:0]  mod_cred_wr,
    output logic [CNT_W-1:0]  adp_cred_rm,
    output logic [CNT_W-1:0]  adp_cred_wr,
    output logic              lock_held,
    output logic              lock_by_adp
);
    localparam int NSIDE = 2;
    localparam int NPOOL = 2;   // pool 0: read/modify, pool 1: write

    logic              s_req   [NSIDE];
    logic [KIND_W-1:0] s_kind  [NSIDE];
    logic              s_clr   [NSIDE];
    logic              s_inc   [NSIDE][NPOOL];
    logic              s_dec   [NSIDE][NPOOL];
    logic [CNT_W-1:0]  s_cred  [NSIDE][NPOOL];
    logic              s_take  [NSIDE][NPOOL];
    logic              s_elig  [NSIDE];
    logic              s_mod   [NSIDE];
    logic              s_wr    [NSIDE];
    logic              s_mine  [NSIDE];
    logic              s_win   [NSIDE];
    logic              lock_q;
    logic              owner_q;

    // Map the port-level signals onto per-side arrays. Each side's credits
    // are returned or cleared by its peer.
    always_comb begin
        s_req[0]    = mod_req;
        s_kind[0]   = mod_kind;
        s_req[1]    = adp_req;
        s_kind[1]   = adp_kind;
        s_clr[0]    = adp_credit_clr;
        s_clr[1]    = mod_credit_clr;
        s_inc[0][0] = adp_free_rm;
        s_inc[0][1] = adp_free_wr;
        s_inc[1][0] = mod_free_rm;
        s_inc[1][1] = mod_free_wr;
    end

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_side
            assign s_mine[s] = lock_q && (owner_q == s[0]);

            link_req_qual #(.CNT_W(CNT_W)) u_qual (
                .req       (s_req[s]),
                .kind      (s_kind[s]),
                .cred_rm   (s_cred[s][0]),
                .cred_wr   (s_cred[s][1]),
                .lock_held (lock_q),
                .lock_mine (s_mine[s]),
                .elig      (s_elig[s]),
                .take_rm   (s_take[s][0]),
                .take_wr   (s_take[s][1]),
                .is_modify (s_mod[s]),
                .is_write  (s_wr[s])
            );

            for (genvar p = 0; p < NPOOL; p++) begin : g_pool
                assign s_dec[s][p] = s_win[s] && s_take[s][p];

                link_credit_ctr #(.CNT_W(CNT_W)) u_ctr (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .inc   (s_inc[s][p]),
                    .dec   (s_dec[s][p]),
                    .clr   (s_clr[s]),
                    .cnt   (s_cred[s][p])
                );
            end
        end
    endgenerate

    // Strict priority: side 0 wins when eligible, side 1 takes the rest.
    always_comb begin
        s_win[0] = s_elig[0];
        s_win[1] = s_elig[1] && !s_elig[0];
    end

    // Register the slot grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_grant <= 1'b0;
            adp_grant <= 1'b0;
        end else begin
            mod_grant <= s_win[0];
            adp_grant <= s_win[1];
        end
    end

    // Open the interlock on a granted modify; the owner's granted write closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            owner_q <= 1'b0;
        end else if (s_win[0] && s_mod[0]) begin
            lock_q  <= 1'b1;
            owner_q <= 1'b0;
        end else if (s_win[1] && s_mod[1]) begin
            lock_q  <= 1'b1;
            owner_q <= 1'b1;
        end else if (lock_q && s_win[owner_q] && s_wr[owner_q]) begin
            lock_q  <= 1'b0;
        end
    end

    assign lock_held   = lock_q;
    assign lock_by_adp = owner_q && lock_q;
    assign mod_cred_rm = s_cred[0][0];
    assign mod_cred_wr = s_cred[0][1];
    assign adp_cred_rm = s_cred[1][0];
    assign adp_cred_wr = s_cred[1][1];

    // R4: never two owners of one slot
    a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mod_grant, adp_grant}));

    // R4: a pending module response always beats the adapter
    a_r4_mod_priority: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mod_req) && kind_is_resp($past(mod_kind))) |-> !adp_grant);

    // R6: illegal kinds and idle requesters are never granted
    a_r6_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        mod_grant |-> ($past(mod_req) && $past(mod_kind) != K_ILL_LO && $past(mod_kind) != K_ILL_HI));

    // R3: a module write is granted only against a nonzero write pool
    a_r3_credit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_grant && $past(mod_kind) == K_WRITE) |-> ($past(mod_cred_wr) != '0));

    // R10: a granted module modify leaves the lock held by the module
    a_r10_lock_take: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_grant && $past(mod_kind) == K_MODIFY) |-> (lock_held && !lock_by_adp));

    // R10: the adapter cannot modify through a module-owned lock
    a_r10_lock_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (adp_grant && $past(adp_kind) == K_MODIFY) |-> !($past(lock_held) && !$past(lock_by_adp)));

endmodule

// File: tb/link_slot_arbiter_tb_top.sv
// Bench: a vector table walked by one loop, then directed tests for
// saturation, adapter-owned lock, clear, and mid-run reset.
module link_slot_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_req = 1'b0, adp_req = 1'b0;
    logic [2:0] mod_kind = 3'd0, adp_kind = 3'd0;
    logic       adp_free_rm = 1'b0, adp_free_wr = 1'b0, adp_credit_clr = 1'b0;
    logic       mod_free_rm = 1'b0, mod_free_wr = 1'b0, mod_credit_clr = 1'b0;
    logic       mod_grant, adp_grant, lock_held, lock_by_adp;
    logic [2:0] mod_cred_rm, mod_cred_wr, adp_cred_rm, adp_cred_wr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    link_slot_arbiter dut_i (
        .clk(clk), .rst_n(rst_n),
        .mod_req(mod_req), .mod_kind(mod_kind),
        .adp_req(adp_req), .adp_kind(adp_kind),
        .adp_free_rm(adp_free_rm), .adp_free_wr(adp_free_wr), .adp_credit_clr(adp_credit_clr),
        .mod_free_rm(mod_free_rm), .mod_free_wr(mod_free_wr), .mod_credit_clr(mod_credit_clr),
        .mod_grant(mod_grant), .adp_grant(adp_grant),
        .mod_cred_rm(mod_cred_rm), .mod_cred_wr(mod_cred_wr),
        .adp_cred_rm(adp_cred_rm), .adp_cred_wr(adp_cred_wr),
        .lock_held(lock_held), .lock_by_adp(lock_by_adp)
    );

    // Row layout: [29] mreq [28:26] mkind [25] areq [24:22] akind
    // [21:16] strobes afr afw aclr mfr mfw mclr,
    // [15:0] expected: mg ag mrm mwr arm awr lock owner_adp
    localparam int NV = 15;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0,3'd0,1'b0,3'd0,6'b100000, 1'b0,1'b0,3'd1,3'd0,3'd0,3'd0,1'b0,1'b0},
        {1'b0,3'd0,1'b0,3'd0,6'b110110, 1'b0,1'b0,3'd2,3'd1,3'd1,3'd1,1'b0,1'b0},
        {1'b1,3'd1,1'b1,3'd1,6'b000000, 1'b1,1'b0,3'd1,3'd1,3'd1,3'd1,1'b0,1'b0},
        {1'b1,3'd2,1'b1,3'd2,6'b000000, 1'b1,1'b0,3'd1,3'd0,3'd1,3'd1,1'b0,1'b0},
        {1'b1,3'd2,1'b1,3'd2,6'b000000, 1'b0,1'b1,3'd1,3'd0,3'd1,3'd0,1'b0,1'b0},
        {1'b1,3'd4,1'b1,3'd1,6'b000000, 1'b1,1'b0,3'd1,3'd0,3'd1,3'd0,1'b0,1'b0},
        {1'b1,3'd7,1'b1,3'd0,6'b000000, 1'b0,1'b0,3'd1,3'd0,3'd1,3'd0,1'b0,1'b0},
        {1'b0,3'd5,1'b1,3'd2,6'b000000, 1'b0,1'b0,3'd1,3'd0,3'd1,3'd0,1'b0,1'b0},
        {1'b1,3'd3,1'b0,3'd0,6'b000000, 1'b1,1'b0,3'd0,3'd0,3'd1,3'd0,1'b1,1'b0},
        {1'b0,3'd0,1'b1,3'd3,6'b000000, 1'b0,1'b0,3'd0,3'd0,3'd1,3'd0,1'b1,1'b0},
        {1'b0,3'd0,1'b1,3'd1,6'b000000, 1'b0,1'b1,3'd0,3'd0,3'd0,3'd0,1'b1,1'b0},
        {1'b1,3'd2,1'b0,3'd0,6'b010000, 1'b0,1'b0,3'd0,3'd1,3'd0,3'd0,1'b1,1'b0},
        {1'b1,3'd2,1'b0,3'd0,6'b010000, 1'b1,1'b0,3'd0,3'd1,3'd0,3'd0,1'b0,1'b0},
        {1'b0,3'd0,1'b0,3'd0,6'b000110, 1'b0,1'b0,3'd0,3'd1,3'd1,3'd1,1'b0,1'b0},
        {1'b0,3'd0,1'b0,3'd0,6'b000101, 1'b0,1'b0,3'd0,3'd1,3'd0,3'd0,1'b0,1'b0}
    };

    function automatic string row_req(input int i);
        case (i)
            0, 1:    return "R8";
            2:       return "R3";
            3:       return "R7";
            4:       return "R5";
            5:       return "R2";
            6, 7:    return "R6";
            8, 9:    return "R10";
            10:      return "R4";
            11:      return "R3";
            12:      return "R8";
            13:      return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [15:0] outs();
        return {mod_grant, adp_grant, mod_cred_rm, mod_cred_wr,
                adp_cred_rm, adp_cred_wr, lock_held, lock_by_adp};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one slot's stimulus at a falling edge, then sample at the next falling edge.
    task automatic cyc(input logic [13:0] s);
        {mod_req, mod_kind, adp_req, adp_kind,
         adp_free_rm, adp_free_wr, adp_credit_clr,
         mod_free_rm, mod_free_wr, mod_credit_clr} = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'(outs()), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][29:16]);
            chk($sformatf("%s table row %0d", row_req(i), i), int'(outs()), int'(VEC[i][15:0]));
        end

        // R8: saturation of the module read/modify pool (starts at 0)
        repeat (9) cyc({8'h00, 6'b100000});
        chk("R8 saturate at 7", int'(mod_cred_rm), 7);

        // R10: adapter-owned lock
        repeat (2) cyc({8'h00, 6'b000100});
        cyc({1'b0, 3'd0, 1'b1, 3'd3, 6'b000000});
        chk("R10 adapter modify takes lock", int'({adp_grant, lock_held, lock_by_adp, adp_cred_rm}), int'({3'b111, 3'd1}));
        cyc({1'b1, 3'd3, 1'b0, 3'd0, 6'b000000});
        chk("R10 module modify blocked", int'({mod_grant, mod_cred_rm}), int'({1'b0, 3'd7}));
        cyc({1'b1, 3'd1, 1'b0, 3'd0, 6'b000000});
        chk("R10 module read passes lock", int'({mod_grant, mod_cred_rm}), int'({1'b1, 3'd6}));
        cyc({1'b0, 3'd0, 1'b1, 3'd2, 6'b000000});
        chk("R5 adapter write without credit", int'({adp_grant, mod_grant, lock_held}), int'(3'b001));
        cyc({8'h00, 6'b000010});
        cyc({1'b0, 3'd0, 1'b1, 3'd2, 6'b000000});
        chk("R10 owner write releases", int'({adp_grant, lock_held, adp_cred_wr}), int'({2'b10, 3'd0}));
        cyc({1'b1, 3'd3, 1'b0, 3'd0, 6'b000000});
        chk("R7 module modify after release", int'({mod_grant, lock_held, lock_by_adp, mod_cred_rm}), int'({3'b110, 3'd5}));

        // R9: adapter clears both module-side pools
        cyc({8'h00, 6'b001000});
        chk("R9 clear both pools", int'({mod_cred_rm, mod_cred_wr}), 0);

        // R1: reset in the middle of traffic
        rst_n = 1'b0;
        cyc({1'b1, 3'd4, 1'b1, 3'd4, 6'b110110});
        chk("R1 mid-run reset", int'(outs()), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule